// File: doc/BRIEF.md
# Control Endpoint Protocol Guard

This block follows the device side of a control transfer on endpoint zero. It does not see raw bus traffic. It takes decoded events: token kind, data packet PID parity and length, and the host's acknowledgement of an IN data packet. It also takes the software actions: accepting the setup request with its direction, marking the data stage complete, requesting a stall, and clearing flags. It keeps the transfer phase, picks the handshake to return for each token or data packet, and stalls the endpoint on its own when the host breaks the control protocol.

When the host closes the data stage early with a zero-length OUT packet, the block pulses a one-cycle flush so the packet-buffer logic can drop queued IN data. It also raises a setup-end flag. The block then waits until software clears that flag before it returns to idle. Three sticky flags report the block's status: packet ready, stall sent and setup end. Their OR drives the interrupt. The packet length limit is taken from a software register when each SETUP token arrives.

Phase codes on `phase`: 0 idle, 1 setup, 2 IN data, 3 OUT data, 4 IN status, 5 OUT status, 6 halted (stalling), 7 aborted (setup end pending). Token codes on `tok_kind`: 0 SETUP, 1 OUT, 2 IN. Handshake codes on `hs_code`: 1 ACK (for an IN token this means the loaded data packet is sent), 2 NAK, 3 STALL. Every output is registered, so the response to an event appears one clock after the event.

Top module: `ctl_ep_guard`

## Requirements
- R1: While reset is high, and in the cycle after it, `phase` reads 0, `hs_vld`, `flush`, all three flags and `irq` read 0.
- R2: A SETUP token moves `phase` to 1 from any phase, including halted, so the stall ends. In phase 1, a data packet is answered with ACK (code 1) and sets `flag_rdy`, and an IN token is answered with NAK (code 2).
- R3: The length limit that applies to a transfer is the value of `sw_max_pkt` in the cycle of that transfer's SETUP token. Later writes to `sw_max_pkt` do not change it.
- R4: In phase 4, which is entered by `sw_data_end` during OUT data, an OUT token moves `phase` to 6. The data packet that follows gets STALL (code 3).
- R5: In phase 5, which is entered by a `host_ack` after `sw_data_end` during IN data, an IN token gets STALL and `phase` becomes 6.
- R6: In phase 3, a data packet longer than the length limit gets STALL and `phase` becomes 6.
- R7: In phase 5, a data packet with the DATA0 PID (`pkt_data1`=0) or a non-zero length gets STALL. A zero-length DATA1 packet gets ACK and `phase` becomes 0.
- R8: A zero-length packet in phase 3, or in phase 2 before `sw_data_end`, gets ACK. It pulses `flush` for exactly one cycle, sets `flag_setupend` and moves `phase` to 7. Phase 7 NAKs IN tokens until `sw_clr_setupend` returns it to 0.
- R9: `sw_stall` moves `phase` to 6. Phase 6 answers every IN token and every data packet with STALL until a SETUP token arrives.
- R10: Each issued STALL sets `flag_sent_stall`. Every flag stays set until its clear input is pulsed, and a set in the same cycle as a clear leaves the flag set.
- R11: `irq` is high exactly when at least one of the three flags is high, in the same cycle.
- R12: In phase 2, an IN token gets ACK when `tx_loaded` is 1 and NAK when it is 0. In phase 3, a data packet gets NAK while `flag_rdy` is set, and otherwise gets ACK and sets `flag_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_vld | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token code: 0 SETUP, 1 OUT, 2 IN |
| pkt_vld | input | 1 | Received data packet strobe |
| pkt_data1 | input | 1 | Packet PID is DATA1 |
| pkt_len | input | LEN_W | Received packet byte count |
| host_ack | input | 1 | Host acknowledged the last IN data packet |
| tx_loaded | input | 1 | An IN data packet is ready to send |
| sw_max_pkt | input | LEN_W | Software packet length limit |
| sw_setup_go | input | 1 | Software accepted the setup request |
| sw_dir_in | input | 1 | Accepted request has an IN data stage |
| sw_no_data | input | 1 | Accepted request has no data stage |
| sw_data_end | input | 1 | Software marks the last data packet |
| sw_stall | input | 1 | Software stall request |
| sw_clr_rdy | input | 1 | Clear packet-ready flag |
| sw_clr_stall | input | 1 | Clear stall-sent flag |
| sw_clr_setupend | input | 1 | Clear setup-end flag |
| hs_vld | output | 1 | Handshake select valid |
| hs_code | output | 2 | Handshake: 1 ACK, 2 NAK, 3 STALL |
| flush | output | 1 | One-cycle buffer flush strobe |
| flag_rdy | output | 1 | Packet-ready flag |
| flag_sent_stall | output | 1 | Stall-sent flag |
| flag_setupend | output | 1 | Setup-end flag |
| irq | output | 1 | Endpoint interrupt |
| phase | output | 3 | Transfer phase code |

## Verification
A flag can be set by the hardware and cleared by software in the same cycle. The clearest case is an IN token arriving while the endpoint is halted and a STALL goes out, with `sw_clr_stall` pulsed in that same cycle. The bench drives both in one clock and expects `flag_sent_stall` and `irq` to stay high. A later clear with no stall alongside it must then drop them. The same overlap is tested for the packet-ready flag: the setup packet arrives while `sw_clr_rdy` is pulsed.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  typedef enum logic [1:0] {
    TK_SETUP = 2'd0,
    TK_OUT   = 2'd1,
    TK_IN    = 2'd2,
    TK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_DIN   = 3'd2,
    PH_DOUT  = 3'd3,
    PH_STIN  = 3'd4,
    PH_STOUT = 3'd5,
    PH_HALT  = 3'd6,
    PH_ABORT = 3'd7
  } ph_e;

  localparam int FLAG_N    = 3;
  localparam int FL_RDY    = 0;
  localparam int FL_STALL  = 1;
  localparam int FL_SETEND = 2;

  typedef struct packed {
    hs_e  resp;
    ph_e  nxt;
    logic abort;
    logic set_rdy;
    logic set_de;
    logic clr_de;
  } act_t;

endpackage

// File: rtl/ctl_ep_cap.sv
module ctl_ep_cap #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ctl_ep_flags.sv
module ctl_ep_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      // set has priority over a simultaneous clear
      assign nxt[i] = set[i] | (flags[i] & ~clr[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= |nxt;
    end
  end
endmodule

// File: rtl/ctl_ep_judge.sv
module ctl_ep_judge
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  ph_e              ph,
  input  logic             tok_vld,
  input  tok_e             tok,
  input  logic             pkt_vld,
  input  logic             pkt_data1,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic             de_q,
  input  logic             rdy_q,
  input  logic             tx_loaded,
  input  logic             host_ack,
  input  logic             sw_setup_go,
  input  logic             sw_dir_in,
  input  logic             sw_no_data,
  input  logic             sw_data_end,
  input  logic             sw_stall,
  input  logic             sw_clr_setupend,
  output act_t             act
);
  logic halting;
  logic is_setup;
  logic de_seen;
  logic zero_len;

  assign halting  = sw_stall || (ph == PH_HALT);
  assign is_setup = tok_vld && (tok == TK_SETUP);
  assign de_seen  = de_q || sw_data_end;
  assign zero_len = (pkt_len == '0);

  always_comb begin
    act         = '0;
    act.resp    = HS_NONE;
    act.nxt     = ph;
    act.set_de  = sw_data_end && (ph == PH_DIN);

    if (is_setup) begin
      act.nxt    = PH_SETUP;
      act.clr_de = 1'b1;
      act.set_de = 1'b0;
    end else if (tok_vld && tok == TK_IN) begin
      if (halting) begin
        act.resp = HS_STALL;
        act.nxt  = PH_HALT;
      end else begin
        case (ph)
          PH_DIN:   act.resp = tx_loaded ? HS_ACK : HS_NAK;
          PH_STIN:  act.resp = HS_ACK;
          PH_STOUT: begin
            act.resp = HS_STALL;
            act.nxt  = PH_HALT;
          end
          default:  act.resp = HS_NAK;
        endcase
      end
    end else if (tok_vld && tok == TK_OUT) begin
      // data stage already closed by software: host must not send more
      if (halting || ph == PH_STIN) act.nxt = PH_HALT;
    end else if (pkt_vld) begin
      if (halting) begin
        act.resp = HS_STALL;
        act.nxt  = PH_HALT;
      end else begin
        case (ph)
          PH_SETUP: begin
            act.resp    = HS_ACK;
            act.set_rdy = 1'b1;
          end
          PH_DOUT: begin
            if (pkt_len > max_len) begin
              act.resp = HS_STALL;
              act.nxt  = PH_HALT;
            end else if (zero_len) begin
              act.resp  = HS_ACK;
              act.abort = 1'b1;
              act.nxt   = PH_ABORT;
            end else if (rdy_q) begin
              act.resp = HS_NAK;
            end else begin
              act.resp    = HS_ACK;
              act.set_rdy = 1'b1;
            end
          end
          PH_DIN: begin
            if (!zero_len) begin
              act.resp = HS_STALL;
              act.nxt  = PH_HALT;
            end else if (de_seen) begin
              act.resp = HS_ACK;
              act.nxt  = PH_IDLE;
            end else begin
              act.resp  = HS_ACK;
              act.abort = 1'b1;
              act.nxt   = PH_ABORT;
            end
          end
          PH_STOUT: begin
            if (!pkt_data1 || !zero_len) begin
              act.resp = HS_STALL;
              act.nxt  = PH_HALT;
            end else begin
              act.resp = HS_ACK;
              act.nxt  = PH_IDLE;
            end
          end
          PH_STIN: begin
            act.resp = HS_STALL;
            act.nxt  = PH_HALT;
          end
          default: act.resp = HS_NAK;
        endcase
      end
    end else if (host_ack) begin
      if (ph == PH_DIN && de_seen) act.nxt = PH_STOUT;
      else if (ph == PH_STIN)      act.nxt = PH_IDLE;
    end

    if (!is_setup) begin
      if (sw_stall) begin
        act.nxt = PH_HALT;
      end else if (act.nxt == ph) begin
        case (ph)
          PH_SETUP: begin
            if (sw_setup_go) begin
              if (sw_no_data)     act.nxt = PH_STIN;
              else if (sw_dir_in) act.nxt = PH_DIN;
              else                act.nxt = PH_DOUT;
            end
          end
          PH_DOUT:  if (sw_data_end)     act.nxt = PH_STIN;
          PH_ABORT: if (sw_clr_setupend) act.nxt = PH_IDLE;
          default:  act.nxt = ph;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_ep_guard.sv
module ctl_ep_guard
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_vld,
  input  logic [1:0]       tok_kind,
  input  logic             pkt_vld,
  input  logic             pkt_data1,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             host_ack,
  input  logic             tx_loaded,
  input  logic [LEN_W-1:0] sw_max_pkt,
  input  logic             sw_setup_go,
  input  logic             sw_dir_in,
  input  logic             sw_no_data,
  input  logic             sw_data_end,
  input  logic             sw_stall,
  input  logic             sw_clr_rdy,
  input  logic             sw_clr_stall,
  input  logic             sw_clr_setupend,
  output logic             hs_vld,
  output logic [1:0]       hs_code,
  output logic             flush,
  output logic             flag_rdy,
  output logic             flag_sent_stall,
  output logic             flag_setupend,
  output logic             irq,
  output logic [2:0]       phase
);
  ph_e               st_q;
  logic              de_q;
  logic [LEN_W-1:0]  max_q;
  act_t              act;
  tok_e              tok;
  logic [FLAG_N-1:0] fl_set;
  logic [FLAG_N-1:0] fl_clr;
  logic [FLAG_N-1:0] fl_q;
  logic              setup_tok;

  assign tok       = tok_e'(tok_kind);
  assign setup_tok = tok_vld && (tok == TK_SETUP);

  ctl_ep_cap #(.W(LEN_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .load (setup_tok),
    .d    (sw_max_pkt),
    .q    (max_q)
  );

  ctl_ep_judge #(.LEN_W(LEN_W)) u_judge (
    .ph              (st_q),
    .tok_vld         (tok_vld),
    .tok             (tok),
    .pkt_vld         (pkt_vld),
    .pkt_data1       (pkt_data1),
    .pkt_len         (pkt_len),
    .max_len         (max_q),
    .de_q            (de_q),
    .rdy_q           (fl_q[FL_RDY]),
    .tx_loaded       (tx_loaded),
    .host_ack        (host_ack),
    .sw_setup_go     (sw_setup_go),
    .sw_dir_in       (sw_dir_in),
    .sw_no_data      (sw_no_data),
    .sw_data_end     (sw_data_end),
    .sw_stall        (sw_stall),
    .sw_clr_setupend (sw_clr_setupend),
    .act             (act)
  );

  always_comb begin
    fl_set            = '0;
    fl_set[FL_RDY]    = act.set_rdy;
    fl_set[FL_STALL]  = (act.resp == HS_STALL);
    fl_set[FL_SETEND] = act.abort;
    fl_clr            = '0;
    fl_clr[FL_RDY]    = sw_clr_rdy;
    fl_clr[FL_STALL]  = sw_clr_stall;
    fl_clr[FL_SETEND] = sw_clr_setupend;
  end

  ctl_ep_flags #(.N(FLAG_N)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (fl_set),
    .clr   (fl_clr),
    .flags (fl_q),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PH_IDLE;
      de_q    <= 1'b0;
      hs_vld  <= 1'b0;
      hs_code <= HS_NONE;
      flush   <= 1'b0;
    end else begin
      st_q    <= act.nxt;
      if (act.clr_de)      de_q <= 1'b0;
      else if (act.set_de) de_q <= 1'b1;
      hs_vld  <= (act.resp != HS_NONE);
      hs_code <= act.resp;
      flush   <= act.abort;
    end
  end

  assign phase           = st_q;
  assign flag_rdy        = fl_q[FL_RDY];
  assign flag_sent_stall = fl_q[FL_STALL];
  assign flag_setupend   = fl_q[FL_SETEND];
endmodule

// File: rtl/ctl_ep_guard_chk.sv
module ctl_ep_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       tok_vld,
  input logic [1:0] tok_kind,
  input logic       pkt_vld,
  input logic       tx_loaded,
  input logic       sw_stall,
  input logic       sw_clr_rdy,
  input logic       sw_clr_stall,
  input logic       hs_vld,
  input logic [1:0] hs_code,
  input logic       flush,
  input logic       flag_rdy,
  input logic       flag_sent_stall,
  input logic       flag_setupend,
  input logic       irq,
  input logic [2:0] phase
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && !hs_vld && !flush && !irq));

  p_setup_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (tok_vld && tok_kind == 2'd0) |=> (phase == 3'd1));

  p_out_after_end_r4: assert property (@(posedge clk) disable iff (rst)
    (tok_vld && tok_kind == 2'd1 && phase == 3'd4) |=> (phase == 3'd6));

  p_flush_single_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  p_flush_flag_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> flag_setupend);

  p_halt_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd6 && !(tok_vld && tok_kind == 2'd0)) |=> (phase == 3'd6));

  p_halt_stalls_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd6 && pkt_vld) |=> (hs_vld && hs_code == 2'd3));

  p_stall_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (hs_vld && hs_code == 2'd3) |-> flag_sent_stall);

  p_rdy_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_rdy && !sw_clr_rdy) |=> flag_rdy);

  p_stall_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_sent_stall && !sw_clr_stall) |=> flag_sent_stall);

  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_rdy || flag_sent_stall || flag_setupend));

  p_in_nak_r12: assert property (@(posedge clk) disable iff (rst)
    (tok_vld && tok_kind == 2'd2 && phase == 3'd2 && !tx_loaded && !sw_stall)
      |=> (hs_vld && hs_code == 2'd2));
endmodule

bind ctl_ep_guard ctl_ep_guard_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .tok_vld         (tok_vld),
  .tok_kind        (tok_kind),
  .pkt_vld         (pkt_vld),
  .tx_loaded       (tx_loaded),
  .sw_stall        (sw_stall),
  .sw_clr_rdy      (sw_clr_rdy),
  .sw_clr_stall    (sw_clr_stall),
  .hs_vld          (hs_vld),
  .hs_code         (hs_code),
  .flush           (flush),
  .flag_rdy        (flag_rdy),
  .flag_sent_stall (flag_sent_stall),
  .flag_setupend   (flag_setupend),
  .irq             (irq),
  .phase           (phase)
);

// File: tb/ctl_ep_guard_test.sv
module ctl_ep_guard_test;
  localparam int LEN_W = 7;

  logic             clk = 1'b0;
  logic             rst;
  logic             tok_vld = 0;
  logic [1:0]       tok_kind = 0;
  logic             pkt_vld = 0;
  logic             pkt_data1 = 0;
  logic [LEN_W-1:0] pkt_len = 0;
  logic             host_ack = 0;
  logic             tx_loaded = 0;
  logic [LEN_W-1:0] sw_max_pkt = 8;
  logic             sw_setup_go = 0, sw_dir_in = 0, sw_no_data = 0;
  logic             sw_data_end = 0, sw_stall = 0;
  logic             sw_clr_rdy = 0, sw_clr_stall = 0, sw_clr_setupend = 0;
  logic             hs_vld, flush, flag_rdy, flag_sent_stall, flag_setupend, irq;
  logic [1:0]       hs_code;
  logic [2:0]       phase;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ctl_ep_guard #(.LEN_W(LEN_W)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tok(input int k);
    tok_vld = 1; tok_kind = 2'(k);
    @(negedge clk); tok_vld = 0;
  endtask

  task automatic pkt(input bit d1, input int len);
    pkt_vld = 1; pkt_data1 = d1; pkt_len = LEN_W'(len);
    @(negedge clk); pkt_vld = 0;
  endtask

  task automatic go(input bit din, input bit nod);
    sw_setup_go = 1; sw_dir_in = din; sw_no_data = nod;
    @(negedge clk); sw_setup_go = 0;
  endtask

  task automatic dend();  sw_data_end = 1;     @(negedge clk); sw_data_end = 0;     endtask
  task automatic hack();  host_ack = 1;        @(negedge clk); host_ack = 0;        endtask
  task automatic crdy();  sw_clr_rdy = 1;      @(negedge clk); sw_clr_rdy = 0;      endtask
  task automatic cstl();  sw_clr_stall = 1;    @(negedge clk); sw_clr_stall = 0;    endtask
  task automatic cse();   sw_clr_setupend = 1; @(negedge clk); sw_clr_setupend = 0; endtask

  task automatic start_ctrl(input int mx, input bit din, input bit nod);
    sw_max_pkt = LEN_W'(mx);
    tok(0); pkt(0, 8); crdy(); go(din, nod);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 hs_vld", hs_vld, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {flag_rdy, flag_sent_stall, flag_setupend}, 0);
  endtask

  task automatic t_setup();
    tok(0);
    chk("R2 setup phase", phase, 1);
    tok(2);
    chk("R2 IN in setup NAK", hs_code, 2);
    sw_clr_rdy = 1;
    pkt(0, 8);                       // set and clear in one cycle
    sw_clr_rdy = 0;
    chk("R2 setup pkt ACK", hs_code, 1);
    chk("R10 rdy set wins", flag_rdy, 1);
    chk("R11 irq with rdy", irq, 1);
    crdy();
    chk("R10 rdy cleared", flag_rdy, 0);
    chk("R11 irq low", irq, 0);
  endtask

  task automatic t_out_xfer();
    start_ctrl(8, 0, 0);
    chk("R12 phase data out", phase, 3);
    tok(1); pkt(0, 8);
    chk("R12 out ACK", hs_code, 1);
    chk("R12 rdy set", flag_rdy, 1);
    tok(1); pkt(1, 4);
    chk("R12 out NAK busy", hs_code, 2);
    crdy(); dend();
    chk("R4 phase status in", phase, 4);
    tok(1);
    chk("R4 halted", phase, 6);
    pkt(0, 2);
    chk("R4 STALL", hs_code, 3);
    chk("R10 stall flag", flag_sent_stall, 1);
    cstl();
  endtask

  task automatic t_maxlen();
    start_ctrl(8, 0, 0);
    sw_max_pkt = 64;
    tok(1); pkt(0, 9);
    chk("R3 R6 oversize STALL", hs_code, 3);
    chk("R6 halted", phase, 6);
    cstl();
    start_ctrl(64, 0, 0);
    sw_max_pkt = 4;
    tok(1); pkt(0, 9);
    chk("R3 latched limit ACK", hs_code, 1);
    crdy();
  endtask

  task automatic t_in_xfer();
    start_ctrl(8, 1, 0);
    chk("R12 phase data in", phase, 2);
    tx_loaded = 0; tok(2);
    chk("R12 IN NAK", hs_code, 2);
    tx_loaded = 1; tok(2);
    chk("R12 IN ACK", hs_code, 1);
    tx_loaded = 0;
    dend(); hack();
    chk("R5 status out", phase, 5);
    tok(2);
    chk("R5 extra IN STALL", hs_code, 3);
    chk("R5 halted", phase, 6);
    cstl();
  endtask

  task automatic t_status_out();
    start_ctrl(8, 1, 0); dend(); hack();
    tok(1); pkt(0, 0);
    chk("R7 DATA0 STALL", hs_code, 3);
    cstl();
    start_ctrl(8, 1, 0); dend(); hack();
    tok(1); pkt(1, 3);
    chk("R7 nonzero STALL", hs_code, 3);
    cstl();
    start_ctrl(8, 1, 0); dend(); hack();
    tok(1); pkt(1, 0);
    chk("R7 good status ACK", hs_code, 1);
    chk("R7 back to idle", phase, 0);
  endtask

  task automatic t_premature();
    start_ctrl(8, 0, 0);
    tok(1); pkt(1, 0);
    chk("R8 zlp ACK", hs_code, 1);
    chk("R8 flush", flush, 1);
    chk("R8 setupend", flag_setupend, 1);
    chk("R8 abort phase", phase, 7);
    @(negedge clk);
    chk("R8 flush one cycle", flush, 0);
    tok(2);
    chk("R8 NAK while aborted", hs_code, 2);
    cse();
    chk("R8 idle after clear", phase, 0);
    chk("R8 flag cleared", flag_setupend, 0);
    start_ctrl(8, 1, 0);
    tok(1); pkt(1, 0);
    chk("R8 zlp in IN data flush", flush, 1);
    cse();
  endtask

  task automatic t_sw_stall();
    start_ctrl(8, 1, 0);
    sw_stall = 1; @(negedge clk); sw_stall = 0;
    chk("R9 halted", phase, 6);
    tx_loaded = 1; tok(2); tx_loaded = 0;
    chk("R9 IN STALL", hs_code, 3);
    chk("R9 sent stall", flag_sent_stall, 1);
    chk("R9 irq", irq, 1);
    tok(1); pkt(1, 0);
    chk("R9 data STALL", hs_code, 3);
    cstl();
    chk("R10 stall cleared", flag_sent_stall, 0);
    sw_clr_stall = 1;
    tok(2);                          // STALL and clear in one cycle
    sw_clr_stall = 0;
    chk("R10 set wins", flag_sent_stall, 1);
    chk("R11 irq held", irq, 1);
    cstl();
    chk("R11 irq dropped", irq, 0);
    tok(0);
    chk("R2 setup ends halt", phase, 1);
    tok(2);
    chk("R2 no stall after setup", hs_code, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_out_xfer();
    t_maxlen();
    t_in_xfer();
    t_status_out();
    t_premature();
    t_sw_stall();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule